// File: doc/BRIEF.md
# Dual-Channel 16-bit Match Timer

This peripheral holds two independent 16-bit counters behind a small register bus. Each channel has a count register, a prescaler divider and a control word. The control word starts or halts the channel, picks up or down counting, and sets the terminal behaviour. A channel can halt on reaching zero, halt when its count equals one of six shared compare registers, or run and wrap with no terminal event.

A compare hit latches a status bit, one bit for each compare register. A second register window holds the status bits and an enable mask. Status bits are cleared by writing ones. A single interrupt line is raised while any enabled status bit is set. A typical one-shot use is to load a start count while the channel is halted, then write control to count down toward a compare value. A free-running up counter serves as a time base.

Top module: `dual_match_timer`

## Requirements
- R1: After reset every count, divider, compare, mask and status register reads 0, both control words read 0x10 (halted), and `irq` is low.
- R2: In the main window (`bus_win`=0), channel c has count at 0x0C*c, divider at 0x0C*c+4 and control at 0x0C*c+8. Compare register N (N=0..5) is at 0x18+4*N. Writes read back. Control reads back only bits 4:0. Any other offset, or offset 0x08 and above in the interrupt window, reads 0.
- R3: Control bit 4 halts the channel when 1. Control bit 3 counts up when 1 and down when 0. A halted channel holds its count.
- R4: With divider D, a running channel steps once every D+1 clocks. A write to the count or the divider restarts this interval.
- R5: Terminal field (control bits 2:0) equal to 7 runs freely, wrapping modulo 2^16 in both directions.
- R6: Terminal field 0: a running channel whose count is 0 sets its halt bit on the next edge, holds 0 and raises no status.
- R7: Terminal field N+1 (N=0..5): on the edge where a running channel's count equals compare register N, status bit N is set, the halt bit is set and the count holds.
- R8: Interrupt window (`bus_win`=1) offset 0x00 reads the six status bits. A write there clears the bits written as 1; zero bits have no effect, and 0x3F clears all.
- R9: Interrupt window offset 0x04 is the enable mask; `irq` is the OR of status AND mask.
- R10: When a compare hit and a clearing write target the same status bit on the same edge, the bit ends up set.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_win | input | 1 | Window select: 0 main registers, 1 interrupt registers |
| bus_addr | input | 6 | Byte offset within the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request, level |

## Verification
Counting is tried from the wrap points 0xFFFE upward and 0x0001 downward. This separates true modulo-2^16 wrapping from saturating or sign errors. A divider of 2 with a mid-run count write tells a correct D+1 interval and phase restart apart from an off-by-one or a free-running prescaler. Zero-terminal and compare-terminal runs are sampled on the cycle just before and the cycle just after the terminal edge, which exposes early or late halting and status on the wrong bit. A clearing write landed on the same edge as a hit shows whether set takes priority.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    localparam int CNT_W        = 16;
    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 6;
    localparam int NUM_CH       = 2;
    localparam int MODE_W       = 3;
    localparam int NUM_MATCH    = 6;
    localparam int CH_STRIDE    = 'h0C;
    localparam int VAL_OFF      = 'h00;
    localparam int DIV_OFF      = 'h04;
    localparam int CTL_OFF      = 'h08;
    localparam int MATCH_BASE   = 'h18;
    localparam int MATCH_STRIDE = 4;
    localparam int STS_OFF      = 'h00;
    localparam int MSK_OFF      = 'h04;
    localparam int HALT_BIT     = 4;
    localparam int UP_BIT       = 3;
    localparam int CTL_W        = HALT_BIT + 1;

    localparam logic [MODE_W-1:0] MODE_ZERO    = 3'd0;
    localparam logic [MODE_W-1:0] MODE_FOREVER = 3'd7;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic              halt;
        logic              up;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{halt: 1'b1, up: 1'b0, mode: MODE_ZERO};

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.halt = w[HALT_BIT];
        c.up   = w[UP_BIT];
        c.mode = w[MODE_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        return DATA_W'({c.halt, c.up, c.mode});
    endfunction

    function automatic logic [ADDR_W-1:0] ch_addr(input int ch, input int off);
        return ADDR_W'(ch * CH_STRIDE + off);
    endfunction

    function automatic logic [ADDR_W-1:0] match_addr(input int idx);
        return ADDR_W'(MATCH_BASE + idx * MATCH_STRIDE);
    endfunction
endpackage

// File: rtl/dmt_match_bank.sv
module dmt_match_bank
    import dmt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_MATCH-1:0]    we,
    input  logic [DATA_W-1:0]       wdata,
    output cnt_t [NUM_MATCH-1:0]    vals
);
    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                vals[i] <= '0;
            else if (we[i])
                vals[i] <= cnt_t'(wdata);
        end
    end
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel
    import dmt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_val,
    input  logic                    wr_div,
    input  logic                    wr_ctrl,
    input  logic [DATA_W-1:0]       wdata,
    input  cnt_t [NUM_MATCH-1:0]    match_vals,
    output cnt_t                    count,
    output cnt_t                    divider,
    output ctrl_t                   ctrl,
    output logic [NUM_MATCH-1:0]    evt
);
    cnt_t phase;
    logic running;
    logic tick;
    logic zero_hit;
    logic term;

    assign running  = !ctrl.halt;
    assign tick     = (phase == divider);
    assign zero_hit = running && (ctrl.mode == MODE_ZERO) && (count == '0);
    assign term     = zero_hit || (|evt);

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
        assign evt[i] = running && (ctrl.mode == MODE_W'(i + 1))
                        && (count == match_vals[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RESET;
        end else if (wr_ctrl) begin
            ctrl <= word_to_ctrl(wdata);
        end else if (term) begin
            ctrl.halt <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            divider <= '0;
        else if (wr_div)
            divider <= cnt_t'(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_val) begin
            count <= cnt_t'(wdata);
        end else if (running && !term && tick) begin
            if (ctrl.up)
                count <= count + cnt_t'(1);
            else
                count <= count - cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wr_val || wr_div || !running || term || tick)
            phase <= '0;
        else
            phase <= phase + cnt_t'(1);
    end
endmodule

// File: rtl/dmt_irq_ctrl.sv
module dmt_irq_ctrl
    import dmt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_MATCH-1:0]    set_vec,
    input  logic                    clr_we,
    input  logic                    msk_we,
    input  logic [DATA_W-1:0]       wdata,
    output logic [NUM_MATCH-1:0]    status,
    output logic [NUM_MATCH-1:0]    mask,
    output logic                    irq
);
    logic [NUM_MATCH-1:0] clr_vec;

    assign clr_vec = clr_we ? wdata[NUM_MATCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else
            status <= (status & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (msk_we)
            mask <= wdata[NUM_MATCH-1:0];
    end

    assign irq = |(status & mask);
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
    import dmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_win,
    input  logic [5:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq
);
    logic                               main_we;
    logic                               irq_we;
    logic [NUM_CH-1:0]                  wr_val;
    logic [NUM_CH-1:0]                  wr_div;
    logic [NUM_CH-1:0]                  wr_ctrl;
    logic [NUM_MATCH-1:0]               match_we;
    cnt_t [NUM_MATCH-1:0]               match_vals;
    cnt_t [NUM_CH-1:0]                  cnt_q;
    cnt_t [NUM_CH-1:0]                  div_q;
    ctrl_t [NUM_CH-1:0]                 ctrl_q;
    logic [NUM_CH-1:0][NUM_MATCH-1:0]   ch_evt;
    logic [NUM_MATCH-1:0]               evt_or;
    logic [NUM_MATCH-1:0]               status;
    logic [NUM_MATCH-1:0]               mask;

    assign main_we = bus_we && !bus_win;
    assign irq_we  = bus_we && bus_win;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign wr_val[c]  = main_we && (bus_addr == ch_addr(c, VAL_OFF));
        assign wr_div[c]  = main_we && (bus_addr == ch_addr(c, DIV_OFF));
        assign wr_ctrl[c] = main_we && (bus_addr == ch_addr(c, CTL_OFF));

        dmt_channel u_ch (
            .clk        (clk),
            .rst        (rst),
            .wr_val     (wr_val[c]),
            .wr_div     (wr_div[c]),
            .wr_ctrl    (wr_ctrl[c]),
            .wdata      (bus_wdata),
            .match_vals (match_vals),
            .count      (cnt_q[c]),
            .divider    (div_q[c]),
            .ctrl       (ctrl_q[c]),
            .evt        (ch_evt[c])
        );
    end

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_mwe
        assign match_we[i] = main_we && (bus_addr == match_addr(i));
    end

    always_comb begin
        evt_or = '0;
        for (int c = 0; c < NUM_CH; c++)
            evt_or = evt_or | ch_evt[c];
    end

    dmt_match_bank u_match (
        .clk   (clk),
        .rst   (rst),
        .we    (match_we),
        .wdata (bus_wdata),
        .vals  (match_vals)
    );

    dmt_irq_ctrl u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_vec (evt_or),
        .clr_we  (irq_we && (bus_addr == ADDR_W'(STS_OFF))),
        .msk_we  (irq_we && (bus_addr == ADDR_W'(MSK_OFF))),
        .wdata   (bus_wdata),
        .status  (status),
        .mask    (mask),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_win) begin
            if (bus_addr == ADDR_W'(STS_OFF))
                bus_rdata = DATA_W'(status);
            else if (bus_addr == ADDR_W'(MSK_OFF))
                bus_rdata = DATA_W'(mask);
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (bus_addr == ch_addr(c, VAL_OFF))
                    bus_rdata = DATA_W'(cnt_q[c]);
                if (bus_addr == ch_addr(c, DIV_OFF))
                    bus_rdata = DATA_W'(div_q[c]);
                if (bus_addr == ch_addr(c, CTL_OFF))
                    bus_rdata = ctrl_to_word(ctrl_q[c]);
            end
            for (int i = 0; i < NUM_MATCH; i++) begin
                if (bus_addr == match_addr(i))
                    bus_rdata = DATA_W'(match_vals[i]);
            end
        end
    end
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker
    import dmt_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  cnt_t  [NUM_CH-1:0]                cnt_q,
    input  cnt_t  [NUM_CH-1:0]                div_q,
    input  ctrl_t [NUM_CH-1:0]                ctrl_q,
    input  logic  [NUM_CH-1:0]                wr_val,
    input  logic  [NUM_CH-1:0]                wr_ctrl,
    input  logic  [NUM_CH-1:0][NUM_MATCH-1:0] ch_evt,
    input  logic  [NUM_MATCH-1:0]             evt_or,
    input  logic  [NUM_MATCH-1:0]             status,
    input  logic                              irq
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R7
        match_halt_chk: assert property (@(posedge clk) disable iff (rst)
            (|ch_evt[c]) && !wr_ctrl[c] |=> ctrl_q[c].halt);

        // R3
        halted_hold_chk: assert property (@(posedge clk) disable iff (rst)
            ctrl_q[c].halt && !wr_val[c] |=> $stable(cnt_q[c]));

        // R6
        zero_halt_chk: assert property (@(posedge clk) disable iff (rst)
            !ctrl_q[c].halt && ctrl_q[c].mode == MODE_ZERO && cnt_q[c] == '0
            && !wr_ctrl[c] && !wr_val[c]
            |=> ctrl_q[c].halt && cnt_q[c] == '0);

        // R5
        wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
            !ctrl_q[c].halt && ctrl_q[c].mode == MODE_FOREVER && ctrl_q[c].up
            && div_q[c] == '0 && !wr_val[c]
            |=> cnt_q[c] == cnt_t'($past(cnt_q[c]) + cnt_t'(1)));
    end

    // R7
    status_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_or != '0) |=> ((status & $past(evt_or)) == $past(evt_or)));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0));
endmodule

bind dual_match_timer dmt_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_q   (cnt_q),
    .div_q   (div_q),
    .ctrl_q  (ctrl_q),
    .wr_val  (wr_val),
    .wr_ctrl (wr_ctrl),
    .ch_evt  (ch_evt),
    .evt_or  (evt_or),
    .status  (status),
    .irq     (irq)
);

// File: tb/sim_dual_match_timer.sv
`timescale 1ns/1ps
module sim_dual_match_timer;
    logic        clk = 1'b0;
    logic        rst;
    logic        we;
    logic        win;
    logic [5:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    dual_match_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (we),
        .bus_win   (win),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic w, input logic [5:0] a, input logic [15:0] d);
        we = 1'b1; win = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic w, input logic [5:0] a, input logic [15:0] exp);
        win = w; addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        chk(tag, {15'b0, irq}, {15'b0, exp});
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic t_reset;
        for (int c = 0; c < 2; c++) begin
            rd("R1 count", 1'b0, 6'(c * 12), 16'h0000);
            rd("R1 divider", 1'b0, 6'(c * 12 + 4), 16'h0000);
            rd("R1 control", 1'b0, 6'(c * 12 + 8), 16'h0010);
        end
        for (int i = 0; i < 6; i++)
            rd("R1 compare", 1'b0, 6'(24 + 4 * i), 16'h0000);
        rd("R1 status", 1'b1, 6'h00, 16'h0000);
        rd("R1 mask", 1'b1, 6'h04, 16'h0000);
        chk_irq("R1 irq", 1'b0);
    endtask

    task automatic t_regmap;
        wr(1'b0, 6'h00, 16'h1234);
        wr(1'b0, 6'h04, 16'h0003);
        wr(1'b0, 6'h08, 16'hFFFF);
        wr(1'b0, 6'h0C, 16'hBEEF);
        wr(1'b0, 6'h10, 16'h00A5);
        for (int i = 0; i < 6; i++)
            wr(1'b0, 6'(24 + 4 * i), 16'(16'h0100 + i));
        rd("R2 ch0 count", 1'b0, 6'h00, 16'h1234);
        rd("R2 ch0 divider", 1'b0, 6'h04, 16'h0003);
        rd("R2 ch0 control bits 4:0", 1'b0, 6'h08, 16'h001F);
        rd("R2 ch1 count", 1'b0, 6'h0C, 16'hBEEF);
        rd("R2 ch1 divider", 1'b0, 6'h10, 16'h00A5);
        rd("R2 ch1 control", 1'b0, 6'h14, 16'h0010);
        for (int i = 0; i < 6; i++)
            rd("R2 compare", 1'b0, 6'(24 + 4 * i), 16'(16'h0100 + i));
        rd("R2 unmapped 0x30", 1'b0, 6'h30, 16'h0000);
        rd("R2 unmapped 0x3C", 1'b0, 6'h3C, 16'h0000);
        rd("R2 misaligned 0x02", 1'b0, 6'h02, 16'h0000);
        rd("R2 irq window 0x08", 1'b1, 6'h08, 16'h0000);
        step(4);
        rd("R3 halted ch0 holds", 1'b0, 6'h00, 16'h1234);
        rd("R3 halted ch1 holds", 1'b0, 6'h0C, 16'hBEEF);
    endtask

    task automatic t_wrap;
        wr(1'b0, 6'h04, 16'h0000);
        wr(1'b0, 6'h00, 16'hFFFE);
        wr(1'b0, 6'h08, 16'h000F);
        rd("R5 up start", 1'b0, 6'h00, 16'hFFFE);
        step(1);
        rd("R5 up 0xFFFF", 1'b0, 6'h00, 16'hFFFF);
        step(1);
        rd("R5 up wraps to 0", 1'b0, 6'h00, 16'h0000);
        wr(1'b0, 6'h08, 16'h0010);
        wr(1'b0, 6'h00, 16'h0001);
        wr(1'b0, 6'h08, 16'h0007);
        rd("R3 down start", 1'b0, 6'h00, 16'h0001);
        step(1);
        rd("R3 down to 0", 1'b0, 6'h00, 16'h0000);
        step(1);
        rd("R5 down wraps to 0xFFFF", 1'b0, 6'h00, 16'hFFFF);
        wr(1'b0, 6'h08, 16'h0010);
        rd("R3 halt takes effect", 1'b0, 6'h00, 16'hFFFE);
        step(5);
        rd("R3 halted count holds", 1'b0, 6'h00, 16'hFFFE);
    endtask

    task automatic t_prescale;
        wr(1'b0, 6'h0C, 16'h0000);
        wr(1'b0, 6'h10, 16'h0002);
        wr(1'b0, 6'h14, 16'h000F);
        step(2);
        rd("R4 no step before D+1 clocks", 1'b0, 6'h0C, 16'h0000);
        step(1);
        rd("R4 step at D+1 clocks", 1'b0, 6'h0C, 16'h0001);
        step(1);
        wr(1'b0, 6'h0C, 16'h0050);
        rd("R4 count write", 1'b0, 6'h0C, 16'h0050);
        step(2);
        rd("R4 phase restarted, no early step", 1'b0, 6'h0C, 16'h0050);
        step(1);
        rd("R4 step after restart", 1'b0, 6'h0C, 16'h0051);
        wr(1'b0, 6'h14, 16'h0010);
        wr(1'b0, 6'h10, 16'h0000);
    endtask

    task automatic t_zero;
        wr(1'b0, 6'h00, 16'h0003);
        wr(1'b0, 6'h08, 16'h0000);
        rd("R6 start", 1'b0, 6'h00, 16'h0003);
        step(3);
        rd("R6 reaches 0", 1'b0, 6'h00, 16'h0000);
        rd("R6 still running", 1'b0, 6'h08, 16'h0000);
        step(1);
        rd("R6 halt bit set", 1'b0, 6'h08, 16'h0010);
        step(2);
        rd("R6 holds 0", 1'b0, 6'h00, 16'h0000);
        rd("R6 no status", 1'b1, 6'h00, 16'h0000);
    endtask

    task automatic t_match;
        wr(1'b1, 6'h04, 16'h0004);
        wr(1'b0, 6'h20, 16'h0005);
        wr(1'b0, 6'h0C, 16'h0002);
        wr(1'b0, 6'h14, 16'h000B);
        step(3);
        rd("R7 count at compare value", 1'b0, 6'h0C, 16'h0005);
        rd("R7 status not yet", 1'b1, 6'h00, 16'h0000);
        chk_irq("R9 irq not yet", 1'b0);
        step(1);
        rd("R7 status bit 2", 1'b1, 6'h00, 16'h0004);
        rd("R7 halt bit set", 1'b0, 6'h14, 16'h001B);
        chk_irq("R9 irq enabled", 1'b1);
        step(3);
        rd("R7 count holds", 1'b0, 6'h0C, 16'h0005);
        wr(1'b1, 6'h04, 16'h0000);
        chk_irq("R9 masked", 1'b0);
        rd("R9 mask read", 1'b1, 6'h04, 16'h0000);
        wr(1'b1, 6'h04, 16'h0004);
        chk_irq("R9 unmasked", 1'b1);
        wr(1'b1, 6'h00, 16'h0000);
        rd("R8 zero write no effect", 1'b1, 6'h00, 16'h0004);
        wr(1'b1, 6'h00, 16'h0003);
        rd("R8 other bits no effect", 1'b1, 6'h00, 16'h0004);
        wr(1'b1, 6'h00, 16'h003F);
        rd("R8 all cleared", 1'b1, 6'h00, 16'h0000);
        chk_irq("R9 irq drops", 1'b0);
    endtask

    task automatic t_collide;
        wr(1'b0, 6'h1C, 16'h0010);
        wr(1'b0, 6'h00, 16'h0010);
        wr(1'b0, 6'h08, 16'h000A);
        wr(1'b1, 6'h00, 16'h0002);
        rd("R10 set wins over clear", 1'b1, 6'h00, 16'h0002);
        rd("R7 ch0 halted", 1'b0, 6'h08, 16'h001A);
        chk_irq("R9 bit1 masked", 1'b0);
        wr(1'b1, 6'h00, 16'h003F);
        rd("R8 cleared after", 1'b1, 6'h00, 16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; we = 1'b0; win = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_wrap();
        t_prescale();
        t_zero();
        t_match();
        t_collide();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule